// File: doc/BRIEF.md
# Serial-Bus Converter Control Register Target

This block is the two-wire serial target that sits in front of a 12-bit digital-to-analog converter. It samples the open-drain clock and data lines with a fast system clock. It pulls the data line low through an output-enable signal. It answers its own 7-bit address and a shared broadcast address.

A write carries two data bytes. The first data byte holds a 2-bit power-down field and the top four code bits. The second data byte holds the low eight code bits. The applied code and mode change only on the rising clock edge of the acknowledge that follows the second data byte. This means a write sent to the broadcast address reaches every converter on the bus at the same instant.

A read returns the applied 16-bit register as two bytes, upper byte first. A start or stop condition that arrives before a write has finished throws away the half-received word, so the converter output stays as it was.

Top module: `i2cdac_top`

## Requirements
- R1: An address byte equal to the device address with the direction bit at 0 is acknowledged, and so are both data bytes that follow it.
- R2: The code output (12 bits, straight binary) and the mode output (00 active, 01 2.5 kΩ to ground, 10 100 kΩ to ground, 11 high impedance) change only on the rising clock edge of the acknowledge that follows the second data byte. The first data byte is laid out as [7:6] unused, [5:4] mode, [3:0] code[11:8]. The second data byte is code[7:0].
- R3: An address byte matching neither address is not acknowledged, and the transfer that follows it changes no output.
- R4: The broadcast address is acknowledged for writes and updates the outputs. It is not acknowledged when the direction bit is 1.
- R5: After reset the code is 0, the mode is 00, the data line is released, and a readback returns two zero bytes.
- R6: A read (direction bit 1) returns {00, mode, code[11:8]} and then code[7:0], MSB first. After the master answers the second byte with NACK, the target releases the line.
- R7: Bits 7:6 of the first data byte are ignored and always read back as 0.
- R8: A start or stop condition before the final acknowledge of a write discards the partial word and leaves the outputs unchanged.
- R9: The update strobe is high for exactly one system clock each time the outputs are loaded.
- R10: A write made while the mode is nonzero overwrites both fields and applies the new mode and code.
- R11: The target changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | When high, the data line is pulled low |
| dac_code | output | 12 | Applied converter code |
| pd_mode | output | 2 | Applied power-down mode |
| upd_strobe | output | 1 | One-cycle pulse when the outputs are loaded |

## Verification
A corrupted bit counter or phase state shows up at the ports within one byte time. It appears as a missing or misplaced acknowledge, a shifted readback byte, or a data-line change while the clock is high. A fault in the staging path shows up as an output change, or a strobe, at the wrong moment: before the final acknowledge, after an aborted frame, or after a foreign address. The bench watches for these within the same transaction. Because every write is followed by a readback, a stale or wrongly packed register field appears within the next read.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;

    localparam int CODE_W = 12;
    localparam int MODE_W = 2;
    localparam int BYTE_W = 8;
    localparam int HI_W   = CODE_W - BYTE_W;

    typedef enum logic [MODE_W-1:0] {
        PD_ACTIVE = 2'b00,
        PD_R2K5   = 2'b01,
        PD_R100K  = 2'b10,
        PD_HIZ    = 2'b11
    } pd_mode_e;

    typedef struct packed {
        pd_mode_e          mode;
        logic [CODE_W-1:0] code;
    } dac_word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACK,
        PH_RX,
        PH_TX,
        PH_MACK,
        PH_HOLD
    } phase_e;

    function automatic logic [BYTE_W-1:0] upper_byte(input dac_word_t w);
        return {2'b00, w.mode, w.code[CODE_W-1:BYTE_W]};
    endfunction

    function automatic logic [BYTE_W-1:0] lower_byte(input dac_word_t w);
        return w.code[BYTE_W-1:0];
    endfunction

    function automatic dac_word_t pack_word(input logic [MODE_W+HI_W-1:0] stash,
                                            input logic [BYTE_W-1:0] lo);
        dac_word_t w;
        w.mode = pd_mode_e'(stash[MODE_W+HI_W-1:HI_W]);
        w.code = {stash[HI_W-1:0], lo};
        return w;
    endfunction

endpackage

// File: rtl/i2cdac_line_sync.sv
module i2cdac_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_in};
            sda_q <= {sda_q[STAGES-1:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_q[STAGES-1];
    assign scl_old = scl_q[STAGES];
    assign sda_now = sda_q[STAGES-1];
    assign sda_old = sda_q[STAGES];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2cdac_link.sv
module i2cdac_link
    import i2cdac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h2A,
    parameter logic [6:0] BCAST_ADDR = 7'h47
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sda_s,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      start_det,
    input  logic      stop_det,
    input  dac_word_t cur_word,
    output logic      sda_oe,
    output logic      load,
    output dac_word_t new_word
);
    phase_e              phase;
    logic [2:0]          bit_cnt;
    logic                byte_full;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [MODE_W+HI_W-1:0] stash;
    logic                is_read;
    logic [1:0]          nbyte;
    logic                mack_ok;

    logic addr_hit;
    always_comb begin
        addr_hit = 1'b0;
        if (rx_sh[7:1] == DEV_ADDR)
            addr_hit = 1'b1;
        else if (rx_sh[7:1] == BCAST_ADDR && !rx_sh[0])
            addr_hit = 1'b1;
    end

    logic [BYTE_W-1:0] up_b, lo_b;
    assign up_b = upper_byte(cur_word);
    assign lo_b = lower_byte(cur_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            byte_full <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            stash     <= '0;
            is_read   <= 1'b0;
            nbyte     <= '0;
            mack_ok   <= 1'b0;
            sda_oe    <= 1'b0;
            load      <= 1'b0;
            new_word  <= '0;
        end else begin
            load <= 1'b0;
            if (start_det) begin
                phase     <= PH_ADDR;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                nbyte     <= '0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_ADDR, PH_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) byte_full <= 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            if (phase == PH_ADDR) begin
                                if (addr_hit) begin
                                    phase   <= PH_ACK;
                                    sda_oe  <= 1'b1;
                                    is_read <= rx_sh[0];
                                end else begin
                                    phase <= PH_HOLD;
                                end
                            end else begin
                                phase  <= PH_ACK;
                                sda_oe <= 1'b1;
                                if (nbyte == 2'd1) stash <= rx_sh[MODE_W+HI_W-1:0];
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_rise && !is_read && nbyte == 2'd2) begin
                            load     <= 1'b1;
                            new_word <= pack_word(stash, rx_sh);
                        end
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                phase  <= PH_TX;
                                nbyte  <= 2'd1;
                                tx_sh  <= up_b;
                                sda_oe <= ~up_b[7];
                            end else if (nbyte == 2'd2) begin
                                phase  <= PH_HOLD;
                                sda_oe <= 1'b0;
                            end else begin
                                phase  <= PH_RX;
                                nbyte  <= nbyte + 2'd1;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                phase  <= PH_MACK;
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) mack_ok <= ~sda_s;
                        if (scl_fall) begin
                            if (mack_ok && nbyte == 2'd1) begin
                                phase   <= PH_TX;
                                nbyte   <= 2'd2;
                                bit_cnt <= '0;
                                tx_sh   <= lo_b;
                                sda_oe  <= ~lo_b[7];
                            end else begin
                                phase <= PH_HOLD;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cdac_out_reg.sv
module i2cdac_out_reg
    import i2cdac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  dac_word_t din,
    output dac_word_t q,
    output logic      strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '{mode: PD_ACTIVE, code: '0};
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) q <= din;
        end
    end
endmodule

// File: rtl/i2cdac_top.sv
module i2cdac_top
    import i2cdac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter logic [6:0] BCAST_ADDR  = 7'h47,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [CODE_W-1:0] dac_code,
    output logic [MODE_W-1:0] pd_mode,
    output logic              upd_strobe
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic load;
    dac_word_t staged, applied;

    i2cdac_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cdac_link #(.DEV_ADDR(DEV_ADDR), .BCAST_ADDR(BCAST_ADDR)) u_link (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .cur_word  (applied),
        .sda_oe    (sda_oe),
        .load      (load),
        .new_word  (staged)
    );

    i2cdac_out_reg u_out (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .din    (staged),
        .q      (applied),
        .strobe (upd_strobe)
    );

    assign dac_code = applied.code;
    assign pd_mode  = applied.mode;
endmodule

// File: rtl/i2cdac_props.sv
module i2cdac_props (
    input logic        clk,
    input logic        rst,
    input logic        scl_in,
    input logic        sda_oe,
    input logic [11:0] dac_code,
    input logic [1:0]  pd_mode,
    input logic        upd_strobe
);
    p_reset_zero_r5: assert property (@(posedge clk)
        rst |=> (dac_code == 12'd0 && pd_mode == 2'd0 && !sda_oe));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |=> !upd_strobe);

    p_change_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (upd_strobe || ($stable(dac_code) && $stable(pd_mode))));

    p_load_in_ack_r2: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |-> sda_oe);

    p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in);
endmodule

bind i2cdac_top i2cdac_props u_props (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .dac_code   (dac_code),
    .pd_mode    (pd_mode),
    .upd_strobe (upd_strobe)
);

// File: tb/sim_i2cdac_top.sv
module sim_i2cdac_top;
    localparam logic [6:0] DEV   = 7'h2A;
    localparam logic [6:0] BCAST = 7'h47;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, upd_strobe;
    logic [11:0] dac_code;
    logic [1:0]  pd_mode;
    logic sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2cdac_top #(.DEV_ADDR(DEV), .BCAST_ADDR(BCAST), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .dac_code   (dac_code),
        .pd_mode    (pd_mode),
        .upd_strobe (upd_strobe)
    );

    int n_chk = 0;
    int n_fail = 0;
    int strobes = 0;
    int hi_glitch = 0;
    logic [11:0] exp_code = '0;
    logic [1:0]  exp_mode = '0;

    always @(posedge clk) if (!rst && upd_strobe) strobes <= strobes + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    // watch: lower data byte of a write, check the R2 update timing
    task automatic send_byte(input logic [7:0] b, input bit watch, output bit ack);
        int s0;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        s0 = strobes;
        if (watch) begin
            chk("R2 no update before final ack", strobes - s0 + int'(dac_code != exp_code), 0);
        end
        m_scl = 1'b1; wq();
        ack = ~sda_line;
        wq();
        if (watch) chk("R2 one update at final ack rise", strobes - s0, 1);
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        logic first;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq();
            first = sda_line;
            wq();
            if (sda_line != first) hi_glitch++;
            b[i] = sda_line;
            m_scl = 1'b0; wq();
        end
        m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] hb, input logic [7:0] lb,
                            input bit watch, output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte({a, 1'b0}, 1'b0, a0);
        send_byte(hb, 1'b0, a1);
        send_byte(lb, watch, a2);
        bus_stop();
    endtask

    task automatic do_read(input string tag, output logic [7:0] hb, output logic [7:0] lb);
        bit ak;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, ak);
        chk({tag, " read address ack"}, ak, 1);
        recv_byte(1'b0, hb);
        recv_byte(1'b1, lb);
        chk({tag, " line released after NACK"}, sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit a0, a1, a2;
        logic [7:0] rh, rl;
        int s0;
        logic [11:0] code;
        logic [7:0] hb;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 reset code", dac_code, 0);
        chk("R5 reset mode", pd_mode, 0);
        chk("R5 reset line released", sda_oe, 0);
        do_read("R5", rh, rl);
        chk("R5 reset readback upper", rh, 0);
        chk("R5 reset readback lower", rl, 0);

        // sweep over all modes and a spread of codes
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 6; k++) begin
                code = (k == 5) ? 12'hFFF : 12'((k * 829 + m * 301) % 4096);
                hb = {(k % 2 == 1) ? 2'b11 : 2'b00, 2'(m), code[11:8]};
                s0 = strobes;
                do_write(DEV, hb, code[7:0], (k == 0), a0, a1, a2);
                exp_code = code;
                exp_mode = 2'(m);
                chk("R1 address ack", a0, 1);
                chk("R1 upper byte ack", a1, 1);
                chk("R1 lower byte ack", a2, 1);
                chk("R2 code applied", dac_code, exp_code);
                chk(m != 0 ? "R10 mode applied while powered down" : "R2 mode applied", pd_mode, exp_mode);
                chk("R9 one strobe per write", strobes - s0, 1);
                do_read("R6", rh, rl);
                chk("R6 readback upper", rh, {2'b00, exp_mode, exp_code[11:8]});
                chk("R6 readback lower", rl, exp_code[7:0]);
                chk("R7 unused bits read as zero", rh[7:6], 0);
            end
        end

        // R10: leave high-impedance mode with a fresh word
        do_write(DEV, 8'h3A, 8'h5C, 1'b0, a0, a1, a2);
        do_write(DEV, 8'h01, 8'h23, 1'b0, a0, a1, a2);
        exp_code = 12'h123; exp_mode = 2'b00;
        chk("R10 code after wake", dac_code, 12'h123);
        chk("R10 mode after wake", pd_mode, 0);

        // R3: foreign address
        s0 = strobes;
        do_write(DEV ^ 7'h01, 8'h2F, 8'hFF, 1'b0, a0, a1, a2);
        chk("R3 foreign address nack", a0, 0);
        chk("R3 no strobe", strobes - s0, 0);
        chk("R3 code kept", dac_code, exp_code);
        chk("R3 mode kept", pd_mode, exp_mode);

        // R4: broadcast write and read
        s0 = strobes;
        do_write(BCAST, 8'h1A, 8'hB7, 1'b0, a0, a1, a2);
        exp_code = 12'hAB7; exp_mode = 2'b01;
        chk("R4 broadcast write ack", a0 & a1 & a2, 1);
        chk("R4 broadcast code", dac_code, exp_code);
        chk("R4 broadcast mode", pd_mode, exp_mode);
        chk("R9 broadcast strobe", strobes - s0, 1);
        bus_start();
        send_byte({BCAST, 1'b1}, 1'b0, a0);
        bus_stop();
        chk("R4 broadcast read nack", a0, 0);

        // R8: repeated start after the upper byte
        s0 = strobes;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a0);
        send_byte(8'h2C, 1'b0, a1);
        bus_start();
        bus_stop();
        chk("R8 start abort no strobe", strobes - s0, 0);
        chk("R8 start abort code kept", dac_code, exp_code);
        chk("R8 start abort mode kept", pd_mode, exp_mode);

        // R8: stop after the upper byte, then a valid write still lands
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, a0);
        send_byte(8'h33, 1'b0, a1);
        bus_stop();
        chk("R8 stop abort code kept", dac_code, exp_code);
        chk("R8 stop abort no strobe", strobes - s0, 0);
        do_write(DEV, 8'h24, 8'h56, 1'b0, a0, a1, a2);
        chk("R8 next write applied", dac_code, 12'h456);
        chk("R8 next write mode", pd_mode, 2'b10);

        chk("R11 read data stable while clock high", hi_glitch, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule